// File: doc/BRIEF.md
# Vectored fixed-priority interrupt controller

This block sits beside an 8-bit CPU with a 16-bit address space. It collects 25 maskable request lines, a software break strobe and the power-up condition. These feed 17 fixed priority levels, and each level has its own pair of vector byte addresses. Each maskable line has a request bit that latches on its qualifying edge. A request raises its level only when the line's enable bit is set and the line is currently selected. A global disable flag suppresses every maskable level at once. The startup level and the break level ignore that flag.

Some levels carry several lines. On those levels the hardware does not order the lines, so the service routine reads the request bits to find the cause. Other levels carry one of two alternative lines, and a select bit picks which one. On every cycle the controller picks the lowest-numbered active level and offers it to the CPU on a valid/ready pair: `irq_valid` is the offer and `irq_ready` is the CPU accepting it. Before it is accepted, the offer is re-evaluated every cycle and may change or drop. A higher level may arrive, or software may clear a bit, so the offer is not held the way stream data is.

Holding `irq_ready` low loses nothing, because the requests simply stay latched. When the offer is accepted, the controller captures the offered level, keeps the level and both vector addresses unchanged, and makes no new offer until the CPU pulses `fetch_done`. Acceptance also sets the global disable flag. Software reaches the request, enable, edge-select and control bits through a byte-wide register port whose reads are combinational.

Top module: `vfp_intc`

## Requirements
- R1: After reset, level 1 (startup) is pending and offered with vectors 0xFFFD/0xFFFC, the global disable flag is 1, and all enable, edge-select and select bits are 0. Accepting level 1 clears its pending state.
- R2: `irq_level` shows the offered level, or the held level while in service. For level p, `vec_hi_addr` = 0xFFFD − 2(p−1) and `vec_lo_addr` = `vec_hi_addr` − 1. When the level is 0 (nothing pending and not in service), both are 0 and `irq_valid` is 0.
- R3: When several levels are active, the lowest level number wins.
- R4: Line-to-level map (line:level). 0:2, 1:3, 2–4:4, 5–7:5, 8:6, 9:7, 10:8, 11:9, 12 and 13:10, 14:11, 15 and 16:12, 17:13, 18 and 19:14, 20 and 21:15, 22–24:16. Lines 0, 1, 12, 14 and 15 latch on a rising edge when their edge-select bit is 1 and on a falling edge when it is 0. Lines 17, 20 and 22 latch on a falling edge only. All other lines latch on a rising edge. A request bit sets at the first clock edge that samples the new line value.
- R5: A maskable line raises its level only while its enable bit is 1. Its request bit is kept either way.
- R6: While the global disable flag is 1, levels 2–16 are never offered, but levels 1 and 17 still are.
- R7: Accepting a level clears the request bit of its line on single-line levels, and of the selected line on alternative levels. Request bits on the shared levels 4, 5 and 16 are left set. Accepting level 17 clears the break pending state. A qualifying edge in the same cycle as the clear leaves the bit set.
- R8: Writing 1 to a request bit clears it, and writing 0 has no effect. A qualifying edge in the same cycle keeps the bit set.
- R9: Acceptance (`irq_valid` and `irq_ready` high together) sets the global disable flag and raises `in_service`. While `in_service` is high, `irq_level` and both vectors stay constant and `irq_valid` is 0. A `fetch_done` pulse while in service ends it.
- R10: Select bits 0–3 choose the alternative on levels 10, 12, 14 and 15 respectively. Value 0 picks the lower-numbered line (12, 15, 18, 20) and value 1 the higher (13, 16, 19, 21). Edges on the unselected line do not set its bit, and that line never raises the level.
- R11: A high `brk_i` makes level 17 pending (vectors 0xFFDD/0xFFDC), regardless of enables and the disable flag. Level 17 ranks below every other level.
- R12: Register map, 8 lines per byte with line 8k+b at byte k bit b. Addresses 0–3 hold the request bits and 4–7 the enable bits. Addresses 8–11 hold the edge-select bits, which exist only for lines 0, 1, 12, 14 and 15 and read 0 elsewhere. Address 12 is control: bit 7 is the global disable flag and bits 3:0 are the select bits. Unused bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 25 | Raw request lines |
| brk_i | input | 1 | Software break strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_valid | output | 1 | Interrupt offer |
| irq_ready | input | 1 | CPU accepts the offer |
| irq_level | output | 5 | Offered or held level, 0 if none |
| vec_hi_addr | output | 16 | High-order vector byte address |
| vec_lo_addr | output | 16 | Low-order vector byte address |
| fetch_done | input | 1 | CPU has fetched both vector bytes |
| in_service | output | 1 | An accepted level is being held |

## Verification
The collision that matters is a request bit being cleared and set in the same cycle. Two cases are covered: an acceptance that clears a single-line bit while that line shows a new qualifying edge, and a software write-one-to-clear that lands on the same clock as an edge. Directed steps provoke both cases and then read the request byte back to show that the bit stayed set. Long random runs of toggling lines, register writes, acceptances and fetch completions keep producing the same collision. A cycle-by-cycle reference model judges every run.

// File: rtl/vfp_pkg.sv
package vfp_pkg;
  localparam int N_SRC  = 25;
  localparam int N_LVL  = 17;
  localparam int N_SEL  = 4;
  localparam int LVL_W  = $clog2(N_LVL + 1);
  localparam int N_BYTE = (N_SRC + 7) / 8;
  localparam int ADDR_W = $clog2(3 * N_BYTE + 1);
  localparam int PAD_W  = 8 * N_BYTE;

  typedef enum logic [1:0] {EK_RISE, EK_PICK, EK_FALL} edge_kind_e;

  // priority level served by each line
  function automatic int src_level(int i);
    case (i)
      0: return 2;
      1: return 3;
      2, 3, 4: return 4;
      5, 6, 7: return 5;
      8: return 6;
      9: return 7;
      10: return 8;
      11: return 9;
      12, 13: return 10;
      14: return 11;
      15, 16: return 12;
      17: return 13;
      18, 19: return 14;
      20, 21: return 15;
      default: return 16;
    endcase
  endfunction

  function automatic edge_kind_e src_kind(int i);
    case (i)
      0, 1, 12, 14, 15: return EK_PICK;
      17, 20, 22:       return EK_FALL;
      default:          return EK_RISE;
    endcase
  endfunction

  // select bit that gates this line, -1 when always present
  function automatic int src_alt(int i);
    case (i)
      12, 13: return 0;
      15, 16: return 1;
      18, 19: return 2;
      20, 21: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit src_alt_val(int i);
    return (i == 13) || (i == 16) || (i == 19) || (i == 21);
  endfunction

  function automatic bit lvl_shared(int l);
    int n;
    n = 0;
    for (int i = 0; i < N_SRC; i++)
      if (src_level(i) == l && src_alt(i) < 0) n++;
    return n > 1;
  endfunction

  function automatic logic [N_SRC-1:0] pick_mask();
    logic [N_SRC-1:0] m;
    for (int i = 0; i < N_SRC; i++) m[i] = (src_kind(i) == EK_PICK);
    return m;
  endfunction

  function automatic logic [15:0] vec_hi(logic [LVL_W-1:0] lvl, logic [15:0] top);
    logic [15:0] d;
    if (lvl == '0) return 16'h0000;
    d = 16'(lvl) - 16'd1;
    return top - (d << 1);
  endfunction
endpackage

// File: rtl/vfp_src_cell.sv
module vfp_src_cell #(
  parameter vfp_pkg::edge_kind_e KIND = vfp_pkg::EK_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic pick_rise_i,
  input  logic active_i,
  input  logic enable_i,
  input  logic clr_i,
  output logic req_o,
  output logic pend_o
);
  logic prev_q, req_q, hit;

  always_comb begin
    case (KIND)
      vfp_pkg::EK_PICK: hit = pick_rise_i ? (raw_i & ~prev_q) : (~raw_i & prev_q);
      vfp_pkg::EK_FALL: hit = ~raw_i & prev_q;
      default:          hit = raw_i & ~prev_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= raw_i;
      req_q  <= (req_q & ~clr_i) | (hit & active_i);
    end
  end

  assign req_o  = req_q;
  assign pend_o = req_q & enable_i & active_i;

  a_r4_edge_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && active_i) |=> req_q);
  a_r10_unselected_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !req_q) |=> !req_q);
  a_r8_clear_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(hit && active_i)) |=> !req_q);
endmodule

// File: rtl/vfp_arbiter.sv
module vfp_arbiter #(
  parameter int N_LVL = 17,
  parameter int LVL_W = 5
) (
  input  logic [N_LVL-1:0] lvl_req_i,
  output logic             any_o,
  output logic [LVL_W-1:0] win_o
);
  always_comb begin
    win_o = '0;
    for (int k = N_LVL - 1; k >= 0; k--)
      if (lvl_req_i[k]) win_o = LVL_W'(k + 1);
  end
  assign any_o = |lvl_req_i;
endmodule

// File: rtl/vfp_ack_ctl.sv
module vfp_ack_ctl #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [LVL_W-1:0] win_i,
  input  logic             ready_i,
  input  logic             fetch_done_i,
  output logic             valid_o,
  output logic [LVL_W-1:0] level_o,
  output logic             busy_o,
  output logic             take_o
);
  logic             busy_q;
  logic [LVL_W-1:0] hold_q;

  assign valid_o = ~busy_q & any_i;
  assign take_o  = valid_o & ready_i;
  assign level_o = busy_q ? hold_q : win_i;
  assign busy_o  = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      hold_q <= win_i;
    end else if (busy_q && fetch_done_i) begin
      busy_q <= 1'b0;
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fetch_done_i) |=> $stable(level_o));
  a_r9_take_captures: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (busy_q && level_o == $past(win_i)));
endmodule

// File: rtl/vfp_intc.sv
module vfp_intc #(
  parameter logic [15:0] VEC_TOP = 16'hFFFD
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [vfp_pkg::N_SRC-1:0]    src_i,
  input  logic                         brk_i,
  input  logic                         reg_we,
  input  logic [vfp_pkg::ADDR_W-1:0]   reg_addr,
  input  logic [7:0]                   reg_wdata,
  output logic [7:0]                   reg_rdata,
  output logic                         irq_valid,
  input  logic                         irq_ready,
  output logic [vfp_pkg::LVL_W-1:0]    irq_level,
  output logic [15:0]                  vec_hi_addr,
  output logic [15:0]                  vec_lo_addr,
  input  logic                         fetch_done,
  output logic                         in_service
);
  import vfp_pkg::*;

  localparam logic [N_SRC-1:0]  PICK_M   = pick_mask();
  localparam logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(3 * N_BYTE);

  logic [N_SRC-1:0] en_q, pick_q, req_v, pend_v, act_v, clr_sw, clr_ack;
  logic [N_SEL-1:0] sel_q;
  logic             gdis_q, rst_pend_q, brk_pend_q;
  logic [N_LVL-1:0] lvl_req;
  logic             any, take;
  logic [LVL_W-1:0] win;
  logic             ctrl_wr, clr_rst, clr_brk;

  assign ctrl_wr = reg_we && (reg_addr == CTRL_ADR);
  assign clr_rst = take && (win == LVL_W'(1));
  assign clr_brk = take && (win == LVL_W'(N_LVL));

  // software write-one-to-clear of request bits
  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      clr_sw[i] = reg_we && (reg_addr == ADDR_W'(i / 8)) && reg_wdata[i % 8];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int LV = src_level(i);
    localparam bit SH = lvl_shared(LV);
    localparam int AS = src_alt(i);
    if (AS < 0) begin : g_fixed
      assign act_v[i] = 1'b1;
    end else begin : g_alt
      assign act_v[i] = (sel_q[AS] == src_alt_val(i));
    end
    assign clr_ack[i] = take && (win == LVL_W'(LV)) && !SH;
    vfp_src_cell #(.KIND(src_kind(i))) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_i      (src_i[i]),
      .pick_rise_i(pick_q[i]),
      .active_i   (act_v[i]),
      .enable_i   (en_q[i]),
      .clr_i      (clr_sw[i] | clr_ack[i]),
      .req_o      (req_v[i]),
      .pend_o     (pend_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      pick_q     <= '0;
      sel_q      <= '0;
      gdis_q     <= 1'b1;
      rst_pend_q <= 1'b1;
      brk_pend_q <= 1'b0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (reg_we && reg_addr == ADDR_W'(N_BYTE + i / 8))
          en_q[i] <= reg_wdata[i % 8];
        if (reg_we && reg_addr == ADDR_W'(2 * N_BYTE + i / 8))
          pick_q[i] <= reg_wdata[i % 8] & PICK_M[i];
      end
      if (ctrl_wr) sel_q <= reg_wdata[N_SEL-1:0];
      if (take) gdis_q <= 1'b1;
      else if (ctrl_wr) gdis_q <= reg_wdata[7];
      if (clr_rst) rst_pend_q <= 1'b0;
      brk_pend_q <= (brk_pend_q & ~clr_brk) | brk_i;
    end
  end

  always_comb begin
    lvl_req = '0;
    lvl_req[0] = rst_pend_q;
    lvl_req[N_LVL-1] = brk_pend_q;
    for (int i = 0; i < N_SRC; i++)
      lvl_req[src_level(i) - 1] = lvl_req[src_level(i) - 1] | (pend_v[i] & ~gdis_q);
  end

  vfp_arbiter #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_arb (
    .lvl_req_i(lvl_req),
    .any_o    (any),
    .win_o    (win)
  );

  vfp_ack_ctl #(.LVL_W(LVL_W)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_i       (any),
    .win_i       (win),
    .ready_i     (irq_ready),
    .fetch_done_i(fetch_done),
    .valid_o     (irq_valid),
    .level_o     (irq_level),
    .busy_o      (in_service),
    .take_o      (take)
  );

  assign vec_hi_addr = vec_hi(irq_level, VEC_TOP);
  assign vec_lo_addr = (irq_level == '0) ? 16'h0000 : vec_hi_addr - 16'd1;

  // register read port
  logic [PAD_W-1:0] req_pad, en_pad, pick_pad;
  assign req_pad  = PAD_W'(req_v);
  assign en_pad   = PAD_W'(en_q);
  assign pick_pad = PAD_W'(pick_q);

  always_comb begin
    reg_rdata = 8'h00;
    for (int b = 0; b < N_BYTE; b++) begin
      if (reg_addr == ADDR_W'(b))              reg_rdata = req_pad[8*b +: 8];
      if (reg_addr == ADDR_W'(N_BYTE + b))     reg_rdata = en_pad[8*b +: 8];
      if (reg_addr == ADDR_W'(2 * N_BYTE + b)) reg_rdata = pick_pad[8*b +: 8];
    end
    if (reg_addr == CTRL_ADR) begin
      reg_rdata[7]         = gdis_q;
      reg_rdata[N_SEL-1:0] = sel_q;
    end
  end

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    gdis_q |-> !(irq_valid && irq_level > LVL_W'(1) && irq_level < LVL_W'(N_LVL)));
  a_r9_take_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> gdis_q);
  a_r1_startup_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pend_q && !in_service) |-> (irq_valid && irq_level == LVL_W'(1)));
  a_r11_brk_pends: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> brk_pend_q);
endmodule

// File: tb/vfp_intc_bench.sv
`timescale 1ns/1ps
module vfp_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] src = '0;
  logic        brk = 1'b0, we = 1'b0, rdy = 1'b0, fd = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wd = '0;
  logic [7:0]  rdata;
  logic        irq_valid, in_service;
  logic [4:0]  irq_level;
  logic [15:0] vhi, vlo;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  vfp_intc u_vfp_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src), .brk_i(brk),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rdata),
    .irq_valid(irq_valid), .irq_ready(rdy), .irq_level(irq_level),
    .vec_hi_addr(vhi), .vec_lo_addr(vlo), .fetch_done(fd), .in_service(in_service)
  );

  // reference model state
  logic [24:0] m_prev = '0, m_req = '0, m_en = '0, m_pick = '0;
  logic [3:0]  m_sel = '0;
  logic        m_gdis = 1'b1, m_rstp = 1'b1, m_brkp = 1'b0, m_busy = 1'b0;
  logic [4:0]  m_hold = '0;

  function automatic int b_lvl(int i);
    if (i == 0) return 2;
    if (i == 1) return 3;
    if (i <= 4) return 4;
    if (i <= 7) return 5;
    if (i <= 11) return i - 2;
    if (i <= 13) return 10;
    if (i == 14) return 11;
    if (i <= 16) return 12;
    if (i == 17) return 13;
    if (i <= 19) return 14;
    if (i <= 21) return 15;
    return 16;
  endfunction
  function automatic int b_kind(int i); // 0 rise, 1 selectable, 2 fall
    if (i == 0 || i == 1 || i == 12 || i == 14 || i == 15) return 1;
    if (i == 17 || i == 20 || i == 22) return 2;
    return 0;
  endfunction
  function automatic bit b_act(int i);
    case (i)
      12: return !m_sel[0]; 13: return m_sel[0];
      15: return !m_sel[1]; 16: return m_sel[1];
      18: return !m_sel[2]; 19: return m_sel[2];
      20: return !m_sel[3]; 21: return m_sel[3];
      default: return 1'b1;
    endcase
  endfunction
  function automatic bit b_shared(int l);
    return l == 4 || l == 5 || l == 16;
  endfunction
  function automatic logic [4:0] m_win();
    if (m_rstp) return 5'd1;
    for (int l = 2; l <= 16; l++)
      for (int i = 0; i < 25; i++)
        if (b_lvl(i) == l && m_req[i] && m_en[i] && b_act(i) && !m_gdis) return 5'(l);
    if (m_brkp) return 5'd17;
    return 5'd0;
  endfunction
  function automatic logic [7:0] m_rd(logic [3:0] a);
    logic [31:0] r, e, p;
    r = 32'(m_req); e = 32'(m_en); p = 32'(m_pick);
    if (a < 4)  return r[8*a +: 8];
    if (a < 8)  return e[8*(a-4) +: 8];
    if (a < 12) return p[8*(a-8) +: 8];
    if (a == 12) return {m_gdis, 3'b000, m_sel};
    return 8'h00;
  endfunction
  function automatic logic [15:0] e_hi(logic [4:0] l);
    return (l == 0) ? 16'h0000 : 16'hFFFD - 16'(2 * (l - 1));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [4:0] w, el;
    logic acc;
    logic [24:0] hit, clr;
    @(posedge clk);
    w = m_win();
    acc = !m_busy && (w != 0) && rdy;
    for (int i = 0; i < 25; i++) begin
      logic h;
      case (b_kind(i))
        0: h = src[i] & ~m_prev[i];
        1: h = m_pick[i] ? (src[i] & ~m_prev[i]) : (~src[i] & m_prev[i]);
        default: h = ~src[i] & m_prev[i];
      endcase
      hit[i] = h & b_act(i);
      clr[i] = (we && addr == 4'(i / 8) && wd[i % 8]) ||
               (acc && w == 5'(b_lvl(i)) && !b_shared(b_lvl(i)));
    end
    m_req = (m_req & ~clr) | hit;
    m_prev = src;
    for (int i = 0; i < 25; i++) begin
      if (we && addr == 4'(4 + i / 8)) m_en[i] = wd[i % 8];
      if (we && addr == 4'(8 + i / 8) && b_kind(i) == 1) m_pick[i] = wd[i % 8];
    end
    if (we && addr == 4'd12) m_sel = wd[3:0];
    if (acc) m_gdis = 1'b1;
    else if (we && addr == 4'd12) m_gdis = wd[7];
    if (acc && w == 5'd1) m_rstp = 1'b0;
    m_brkp = (m_brkp & ~(acc && w == 5'd17)) | brk;
    if (acc) begin m_busy = 1'b1; m_hold = w; end
    else if (m_busy && fd) m_busy = 1'b0;
    @(negedge clk);
    el = m_busy ? m_hold : m_win();
    chk("R9 irq_valid", 32'(irq_valid), 32'(!m_busy && m_win() != 0));
    chk("R3 irq_level", 32'(irq_level), 32'(el));
    chk("R2 vec_hi", 32'(vhi), 32'(e_hi(el)));
    chk("R2 vec_lo", 32'(vlo), 32'((el == 0) ? 16'h0 : e_hi(el) - 16'd1));
    chk("R9 in_service", 32'(in_service), 32'(m_busy));
    chk("R12 reg_rdata", 32'(rdata), 32'(m_rd(addr)));
    we = 1'b0; rdy = 1'b0; fd = 1'b0; brk = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wd = d;
    step();
  endtask

  task automatic rdchk(string tag, logic [3:0] a, logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic outchk(string tag, logic v, logic [4:0] l, logic [15:0] h, logic [15:0] lo);
    chk({tag, " valid"}, 32'(irq_valid), 32'(v));
    chk({tag, " level"}, 32'(irq_level), 32'(l));
    chk({tag, " hi"}, 32'(vhi), 32'(h));
    chk({tag, " lo"}, 32'(vlo), 32'(lo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=expired exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    outchk("R1 startup offer", 1'b1, 5'd1, 16'hFFFD, 16'hFFFC);
    rdchk("R1 control after reset", 4'd12, 8'h80);
    rdchk("R1 enables after reset", 4'd4, 8'h00);
    // accept startup level
    rdy = 1'b1; step();
    chk("R9 in service after accept", 32'(in_service), 32'd1);
    outchk("R9 held startup", 1'b0, 5'd1, 16'hFFFD, 16'hFFFC);
    step();
    chk("R9 still held", 32'(irq_level), 32'd1);
    fd = 1'b1; step();
    outchk("R1 startup cleared", 1'b0, 5'd0, 16'h0, 16'h0);
    // single line level 6
    wr(4'd5, 8'h01);
    wr(4'd12, 8'h00);
    src[8] = 1'b1; step();
    outchk("R4 rising line 8", 1'b1, 5'd6, 16'hFFF3, 16'hFFF2);
    rdchk("R4 request byte1", 4'd1, 8'h01);
    wr(4'd5, 8'h0B);
    src[9] = 1'b1; src[11] = 1'b1; step();
    outchk("R3 level 6 over 7 and 9", 1'b1, 5'd6, 16'hFFF3, 16'hFFF2);
    wr(4'd1, 8'h01);
    outchk("R8 cleared line 8", 1'b1, 5'd7, 16'hFFF1, 16'hFFF0);
    wr(4'd12, 8'h80);
    outchk("R6 masked", 1'b0, 5'd0, 16'h0, 16'h0);
    brk = 1'b1; step();
    outchk("R11 break while masked", 1'b1, 5'd17, 16'hFFDD, 16'hFFDC);
    rdy = 1'b1; step();
    chk("R11 break in service", 32'(irq_level), 32'd17);
    fd = 1'b1; step();
    outchk("R7 break cleared", 1'b0, 5'd0, 16'h0, 16'h0);
    wr(4'd12, 8'h00);
    outchk("R6 unmasked", 1'b1, 5'd7, 16'hFFF1, 16'hFFF0);
    rdy = 1'b1; step();
    rdchk("R9 accept sets disable", 4'd12, 8'h80);
    fd = 1'b1; step();
    wr(4'd12, 8'h00);
    outchk("R7 line 9 cleared by accept", 1'b1, 5'd9, 16'hFFED, 16'hFFEC);
    wr(4'd5, 8'h01);
    outchk("R5 disabled line", 1'b0, 5'd0, 16'h0, 16'h0);
    rdchk("R5 request kept", 4'd1, 8'h08);
    wr(4'd1, 8'h08);
    // shared level 4
    wr(4'd4, 8'h04);
    src[2] = 1'b1; step();
    outchk("R4 shared line 2", 1'b1, 5'd4, 16'hFFF7, 16'hFFF6);
    rdy = 1'b1; step();
    fd = 1'b1; step();
    rdchk("R7 shared kept", 4'd0, 8'h04);
    wr(4'd12, 8'h00);
    chk("R7 shared reoffered", 32'(irq_level), 32'd4);
    src[2] = 1'b0; step();
    src[2] = 1'b1; we = 1'b1; addr = 4'd0; wd = 8'h04; step();
    rdchk("R8 edge beats clear", 4'd0, 8'h04);
    wr(4'd0, 8'h04);
    rdchk("R8 clear", 4'd0, 8'h00);
    // alternatives on level 10
    wr(4'd5, 8'h20);
    src[13] = 1'b1; step();
    rdchk("R10 unselected ignored", 4'd1, 8'h00);
    chk("R10 no offer", 32'(irq_valid), 32'd0);
    wr(4'd12, 8'h01);
    src[13] = 1'b0; step();
    src[13] = 1'b1; step();
    rdchk("R10 selected latched", 4'd1, 8'h20);
    outchk("R10 level 10", 1'b1, 5'd10, 16'hFFEB, 16'hFFEA);
    // edge select on line 0
    wr(4'd4, 8'h01);
    src[0] = 1'b1; step();
    rdchk("R4 falling mode ignores rise", 4'd0, 8'h00);
    src[0] = 1'b0; step();
    rdchk("R4 falling mode latches", 4'd0, 8'h01);
    outchk("R3 level 2 over 10", 1'b1, 5'd2, 16'hFFFB, 16'hFFFA);
    wr(4'd8, 8'hFF);
    rdchk("R12 edge-select mask", 4'd8, 8'h03);
    src[0] = 1'b1; rdy = 1'b1; step();
    rdchk("R7 edge beats accept clear", 4'd0, 8'h01);
    fd = 1'b1; step();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < 25; i++)
        if ($urandom % 16 == 0) src[i] = ~src[i];
      we   = ($urandom % 6 == 0);
      addr = 4'($urandom % 14);
      wd   = 8'($urandom);
      rdy  = 1'($urandom % 2);
      fd   = ($urandom % 4 == 0);
      brk  = ($urandom % 40 == 0);
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule